// File: doc/BRIEF.md
# Sectioned Prefix Carry-Select Adder

This block adds two unsigned words and a carry input, and returns a word-wide sum and a carry output. The word is cut into 4-bit sections. Inside each section a small parallel-prefix network forms the carries: first the generate/propagate pairs of each bit, then pair spans, then the full nibble span, then one back-filled span for the third carry. Every section above the lowest holds two such adders, one built for an incoming carry of 0 and one for an incoming carry of 1. Both work at once. The real carry arriving from the section below then picks one result through a bank of 2:1 multiplexers.

The lowest section has a single prefix adder that takes the external carry input directly. Each higher section's select is the chosen carry-out of the section beneath it. The top section's chosen carry-out is the carry output of the adder. A parameter can place a register on the sum and carry outputs. That register has a synchronous, active-high reset, so the combinational core can be timed on its own between flops.

Top module: `sps_csel_adder`

## Requirements
- R1: With the output register off, the 17-bit value {cout, sum} equals a + b + cin for every input combination, in the same cycle as the inputs.
- R2: In every section above the lowest, the result built for carry-in 1 (4 sum bits plus carry-out) equals the result built for carry-in 0 plus one.
- R3: The carry that enters the section starting at bit 4k (k = 1, 2, 3) equals bit 4k of the sum of the low 4k bits of a and b plus cin. The carry output equals this carry for k = 4.
- R4: All-ones plus all-ones with cin = 1 gives sum 16'hFFFF with cout = 1.
- R5: A carry that enters at bit 0 ripples through every section boundary. a = 16'hFFFF, b = 0, cin = 1 gives sum 0 and cout = 1. (2^(4k) − 1) + 1 gives exactly 2^(4k) for k = 1, 2, 3.
- R6: Zero plus zero with cin = 0 gives sum 0 and cout = 0. Sections that each generate their own carry out of bit 3 (a = b = 16'h8888) give the arithmetic result, sum 16'h1110 and cout 1.
- R7: With the output register on, sum and cout show the result of the inputs present at the previous rising clock edge. While rst is 1 at a rising edge, both become 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry input |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry output |

## Verification
The hardest case to reach from the ports is the one where the carry-in-1 candidate of a section is actually chosen and a carry has crossed several boundaries to get there. Random operands seldom make a long chain of propagating nibbles. The bench therefore drives operands whose low sections are all ones, so a single carry at bit 0 must cross one, two, three and four boundaries in turn. It adds the all-ones and zero cases, and cases where each section generates its own carry, then a random sweep.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int SEC_W = 4;

  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // bit-level pre-processing
  function automatic pg_t bit_pg(input logic x, input logic y);
    pg_t r;
    r.g = x & y;
    r.p = x ^ y;
    return r;
  endfunction

  // black cell: group generate and group propagate
  function automatic pg_t black_cell(input pg_t hi, input pg_t lo);
    pg_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // grey cell: group generate only
  function automatic logic grey_cell(input pg_t hi, input logic lo_g);
    return hi.g | (hi.p & lo_g);
  endfunction

endpackage

// File: rtl/bk_nibble_add.sv
module bk_nibble_add
  import csel_pkg::*;
(
  input  logic [SEC_W-1:0] a,
  input  logic [SEC_W-1:0] b,
  input  logic             cin,
  output logic [SEC_W-1:0] sum,
  output logic             cout
);

  pg_t             pgb [SEC_W];
  pg_t             span_10;
  pg_t             span_32;
  pg_t             span_30;
  pg_t             span_20;
  logic [SEC_W-1:0] carry;

  always_comb begin
    for (int i = 0; i < SEC_W; i++) begin
      pgb[i] = bit_pg(a[i], b[i]);
    end
    // up-sweep: pairs, then full span
    span_10 = black_cell(pgb[1], pgb[0]);
    span_32 = black_cell(pgb[3], pgb[2]);
    span_30 = black_cell(span_32, span_10);
    // back-fill of the third position
    span_20 = black_cell(pgb[2], span_10);
    // fold the incoming carry in with grey cells
    carry[0] = grey_cell(pgb[0], cin);
    carry[1] = grey_cell(span_10, cin);
    carry[2] = grey_cell(span_20, cin);
    carry[3] = grey_cell(span_30, cin);
    // post-processing
    sum[0] = pgb[0].p ^ cin;
    for (int i = 1; i < SEC_W; i++) begin
      sum[i] = pgb[i].p ^ carry[i-1];
    end
    cout = carry[SEC_W-1];
  end

endmodule

// File: rtl/csel_section.sv
module csel_section
  import csel_pkg::*;
(
  input  logic [SEC_W-1:0] a,
  input  logic [SEC_W-1:0] b,
  input  logic             sel,
  output logic [SEC_W-1:0] sum,
  output logic             cout,
  output logic [SEC_W-1:0] cand0_sum,
  output logic             cand0_cout,
  output logic [SEC_W-1:0] cand1_sum,
  output logic             cand1_cout
);

  bk_nibble_add u_cand0 (
    .a    (a),
    .b    (b),
    .cin  (1'b0),
    .sum  (cand0_sum),
    .cout (cand0_cout)
  );

  bk_nibble_add u_cand1 (
    .a    (a),
    .b    (b),
    .cin  (1'b1),
    .sum  (cand1_sum),
    .cout (cand1_cout)
  );

  // one 2:1 mux per output bit, plus one for the carry
  genvar i;
  generate
    for (i = 0; i < SEC_W; i++) begin : g_mux
      assign sum[i] = sel ? cand1_sum[i] : cand0_sum[i];
    end
  endgenerate
  assign cout = sel ? cand1_cout : cand0_cout;

endmodule

// File: rtl/sps_csel_adder.sv
module sps_csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NUM_SEC = WIDTH / SEC_W;
  localparam int SW1     = SEC_W + 1;
  localparam int WW1     = WIDTH + 1;

  // carry arriving at each section boundary; index NUM_SEC is the carry out
  logic [NUM_SEC:0] sec_cin;
  logic [WIDTH-1:0] sum_comb;

  assign sec_cin[0] = cin;

  // arithmetic view of the carry into bit n
  function automatic logic carry_into(input logic [WIDTH-1:0] x,
                                      input logic [WIDTH-1:0] y,
                                      input logic ci, input int n);
    logic [WIDTH:0] m;
    logic [WIDTH:0] t;
    m = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    t = ({1'b0, x} & m) + ({1'b0, y} & m) + WW1'(ci);
    return t[n];
  endfunction

  genvar k;
  generate
    for (k = 0; k < NUM_SEC; k++) begin : g_sec
      if (k == 0) begin : g_low
        bk_nibble_add u_low (
          .a    (a[SEC_W-1:0]),
          .b    (b[SEC_W-1:0]),
          .cin  (sec_cin[0]),
          .sum  (sum_comb[SEC_W-1:0]),
          .cout (sec_cin[1])
        );
      end else begin : g_sel
        logic [SEC_W-1:0] c0_sum;
        logic [SEC_W-1:0] c1_sum;
        logic             c0_cout;
        logic             c1_cout;

        csel_section u_sec (
          .a          (a[k*SEC_W +: SEC_W]),
          .b          (b[k*SEC_W +: SEC_W]),
          .sel        (sec_cin[k]),
          .sum        (sum_comb[k*SEC_W +: SEC_W]),
          .cout       (sec_cin[k+1]),
          .cand0_sum  (c0_sum),
          .cand0_cout (c0_cout),
          .cand1_sum  (c1_sum),
          .cand1_cout (c1_cout)
        );

        // R2: the two candidates differ by exactly one
        assert_cand_step_R2 : assert property (@(posedge clk) disable iff (rst)
          {c1_cout, c1_sum} == SW1'({c0_cout, c0_sum}) + SW1'(1));
      end

      // R3: selected carry at each boundary matches the arithmetic carry
      assert_boundary_carry_R3 : assert property (@(posedge clk) disable iff (rst)
        sec_cin[k+1] == carry_into(a, b, cin, (k+1)*SEC_W));
    end
  endgenerate

  // R1: combinational result is the exact 17-bit sum
  assert_exact_sum_R1 : assert property (@(posedge clk) disable iff (rst)
    {sec_cin[NUM_SEC], sum_comb} == ({1'b0, a} + {1'b0, b} + WW1'(cin)));

  generate
    if (REG_OUT) begin : g_reg
      logic [WIDTH-1:0] sum_q;
      logic             cout_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          sum_q  <= '0;
          cout_q <= 1'b0;
        end else begin
          sum_q  <= sum_comb;
          cout_q <= sec_cin[NUM_SEC];
        end
      end

      assign sum  = sum_q;
      assign cout = cout_q;

      // R7: registered output is last cycle's combinational result
      assert_reg_latency_R7 : assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ({cout_q, sum_q} == $past({sec_cin[NUM_SEC], sum_comb})));
      // R7: reset clears the register
      assert_reg_reset_R7 : assert property (@(posedge clk)
        $past(rst) |-> ({cout_q, sum_q} == '0));
    end else begin : g_comb
      assign sum  = sum_comb;
      assign cout = sec_cin[NUM_SEC];
    end
  endgenerate

endmodule

// File: tb/sps_csel_adder_bench.sv
module sps_csel_adder_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_c;
  logic         cout_c;
  logic [W-1:0] sum_r;
  logic         cout_r;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sps_csel_adder #(.WIDTH(W), .REG_OUT(1'b0)) u_sps_csel_adder (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum_c), .cout(cout_c)
  );

  sps_csel_adder #(.WIDTH(W), .REG_OUT(1'b1)) u_sps_csel_adder_reg (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum_r), .cout(cout_r)
  );

  // bench reference: bit-serial ripple
  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic ci);
    logic [W:0] r;
    logic       c;
    c = ci;
    for (int i = 0; i < W; i++) begin
      r[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] | y[i]));
    end
    r[W] = c;
    return r;
  endfunction

  task automatic check17(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic apply_comb(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci,
                            input string req);
    @(negedge clk);
    a = x; b = y; cin = ci;
    #1;
    check17(req, {cout_c, sum_c}, ref_add(x, y, ci));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check17("R7 reset clears register", {cout_r, sum_r}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_zero_and_generate;
    apply_comb(16'h0000, 16'h0000, 1'b0, "R6 zero");
    check17("R6 zero literal", {cout_c, sum_c}, 17'h00000);
    apply_comb(16'h8888, 16'h8888, 1'b0, "R6 generate per section");
    check17("R6 generate literal", {cout_c, sum_c}, 17'h11110);
  endtask

  task automatic t_all_ones;
    apply_comb(16'hFFFF, 16'hFFFF, 1'b1, "R4 all ones");
    check17("R4 all ones literal", {cout_c, sum_c}, 17'h1FFFF);
  endtask

  task automatic t_boundary_ripple;
    apply_comb(16'hFFFF, 16'h0000, 1'b1, "R5 ripple all boundaries");
    check17("R5 ripple literal", {cout_c, sum_c}, 17'h10000);
    for (int s = 1; s < 4; s++) begin
      logic [W-1:0] lo;
      lo = W'((32'd1 << (4 * s)) - 1);
      apply_comb(lo, 16'h0001, 1'b0, "R5 boundary crossing");
      check17("R5 boundary literal", {cout_c, sum_c}, 17'(32'd1 << (4 * s)));
      apply_comb(16'hFFFF ^ lo, lo, 1'b1, "R3 select high candidates");
    end
  endtask

  task automatic t_random;
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 400; n++) begin
      apply_comb(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    end
    for (int n = 0; n < 64; n++) begin
      apply_comb(W'($urandom) | 16'h0F0F, ~W'($urandom) | 16'hF0F0, 1'($urandom),
                 "R2 candidate mix");
    end
  endtask

  task automatic t_registered;
    logic [W:0] exp_prev;
    @(negedge clk);
    a = 16'h1234; b = 16'hEDCC; cin = 1'b0;
    exp_prev = ref_add(16'h1234, 16'hEDCC, 1'b0);
    @(posedge clk); #1;
    check17("R7 one-cycle latency", {cout_r, sum_r}, exp_prev);
    @(negedge clk);
    a = 16'h00FF; b = 16'h0001; cin = 1'b1;
    #1;
    check17("R7 holds until edge", {cout_r, sum_r}, exp_prev);
    @(posedge clk); #1;
    check17("R7 next value", {cout_r, sum_r}, ref_add(16'h00FF, 16'h0001, 1'b1));
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check17("R7 reset mid-run", {cout_r, sum_r}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_zero_and_generate;
    t_all_ones;
    t_boundary_ripple;
    t_random;
    t_registered;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule